// File: doc/BRIEF.md
# Counter-Timed SPI Master (Clock Phase 1)

This block is a serial peripheral master that runs only clock phase 1 transfers. A counter split into two 8-bit halves makes the serial clock. The low half times each half-period of SCK. The high half counts the SCK edges of a word. A transmit shift register and a receive shift register move one word per frame, and the word is framed by a start phase and a stop phase that each last one half-period.

Software, or a DMA engine driven by the two request flags, writes a transmit holding register and reads a receive holding register. Each register can be accessed through a straight view or a bit-reversed view, so the same LSB-first wire order also serves MSB-first traffic. When a new word is waiting at the end of a frame, the next frame starts at once and the active-low select stays asserted. This lets a stream of words share one select window.

Top module: `spi_tmr_master`

## Requirements
- R1: After reset, ss_no is 1, sck_o sits at its idle level, tx_req_o is 1, rx_req_o is 0 and ovr_err_o is 0.
- R2: With C = cfg_half_i, each SCK half-period lasts C+1 clock cycles. The first SCK edge of a frame comes C+1 cycles after ss_no falls. SCK toggles only while ss_no is 0.
- R3: The idle level of sck_o is cfg_sck_inv_i, so it is 0 when there is no inversion. The inversion acts only at the pin and does not move data timing.
- R4: mosi_o changes only on a leading SCK edge, which is the edge away from the idle level. miso_i is sampled on the trailing edge. Bit i of the stored transmit word is the i-th bit on the wire, starting from i = 0.
- R5: With wr_rev_i = 0 the written word is stored as it is. With wr_rev_i = 1 it is stored bit-reversed, so written bit W-1 goes out first. With rd_rev_i = 0, rd_data_o bit i is the i-th received bit. With rd_rev_i = 1, the first received bit appears at bit W-1.
- R6: A write drops tx_req_o on the next cycle. tx_req_o rises again once the shifter takes the word, which is one cycle after the write when the block is idle.
- R7: rx_req_o rises when a word completes and falls after a read (rd_en_i). If a read and a word completion happen in the same cycle, rx_req_o stays 1, no overrun is flagged, and the read returns the older word.
- R8: If a word completes while rx_req_o is 1 and no read happens in that cycle, ovr_err_o is set. The new word replaces the held one. ovr_err_o stays set until reset.
- R9: If a word is waiting when the stop phase ends, the next frame begins at once and ss_no stays 0. Completions of back-to-back words are then (2W+1)(C+1) cycles apart, and the gap from the last edge of one word to the first edge of the next is 2(C+1) cycles.
- R10: If no word is waiting when the stop phase ends, ss_no returns to 1 and SCK stays idle until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_half_i | input | CNT_W | Half-period compare value C |
| cfg_sck_inv_i | input | 1 | Invert SCK at the pin (sets its idle level) |
| wr_en_i | input | 1 | Write strobe for the transmit holding register |
| wr_rev_i | input | 1 | Write through the bit-reversed view |
| wr_data_i | input | DATA_W | Transmit data |
| rd_en_i | input | 1 | Read strobe; clears the receive flag |
| rd_rev_i | input | 1 | Read through the bit-reversed view |
| rd_data_o | output | DATA_W | Receive holding register, as seen through the selected view |
| tx_req_o | output | 1 | Transmit holding register may be written |
| rx_req_o | output | 1 | Received word is ready to read |
| ovr_err_o | output | 1 | Sticky receive overrun |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_no | output | 1 | Slave select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
A read of the receive register and the completion of the next word can fall in the same clock cycle. Two words are streamed back to back. The cycle in which the first word completes is measured, and from that the cycle in which the second word completes is known exactly. The read strobe is placed on that one cycle. The outcome is judged by four checks: the read returns the first word, rx_req_o stays 1, ovr_err_o stays 0, and a second read returns the second word.

// File: rtl/spi_tmr_pkg.sv
package spi_tmr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/spi_bit_view.sv
module spi_bit_view #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         rev_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flip;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flip[i] = d_i[W-1-i];
  end

  assign q_o = rev_i ? flip : d_i;
endmodule

// File: rtl/spi_half_timer.sv
// Dual-half counter: low half times SCK half-periods, high half counts edges.
module spi_half_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             edge_clr_i,
  input  logic             edge_inc_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] edge_cnt_o
);
  logic [CNT_W-1:0] hp_q;
  logic [CNT_W-1:0] edge_q;

  assign tick_o     = run_i && (hp_q == '0);
  assign edge_cnt_o = edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_q <= '0;
    end else if (reload_i) begin
      hp_q <= cmp_i;
    end else if (run_i) begin
      hp_q <= (hp_q == '0) ? cmp_i : hp_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
    end else if (edge_clr_i) begin
      edge_q <= '0;
    end else if (tick_o && edge_inc_i) begin
      edge_q <= edge_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_data_bufs.sv
module spi_data_bufs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_rev_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  input  logic         rd_en_i,
  input  logic         rd_rev_i,
  input  logic         land_i,
  input  logic [W-1:0] land_data_i,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] tx_word_o,
  output logic         tx_full_o,
  output logic         rx_full_o,
  output logic         ovr_o
);
  logic [W-1:0] wr_view;
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;
  logic         tx_full_q;
  logic         rx_full_q;
  logic         ovr_q;

  spi_bit_view #(.W(W)) u_wr_view (.d_i(wr_data_i), .rev_i(wr_rev_i), .q_o(wr_view));
  spi_bit_view #(.W(W)) u_rd_view (.d_i(rx_q),      .rev_i(rd_rev_i), .q_o(rd_data_o));

  // a write in the take cycle wins: the old word leaves, the new one stays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      tx_full_q <= 1'b0;
    end else if (wr_en_i) begin
      tx_q      <= wr_view;
      tx_full_q <= 1'b1;
    end else if (take_i) begin
      tx_full_q <= 1'b0;
    end
  end

  // an arriving word wins over a read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else if (land_i) begin
      rx_q      <= land_data_i;
      rx_full_q <= 1'b1;
      if (rx_full_q && !rd_en_i) ovr_q <= 1'b1;
    end else if (rd_en_i) begin
      rx_full_q <= 1'b0;
    end
  end

  assign tx_word_o = tx_q;
  assign tx_full_o = tx_full_q;
  assign rx_full_o = rx_full_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
  import spi_tmr_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_full_i,
  input  logic [W-1:0]     tx_word_i,
  input  logic             miso_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] edge_cnt_i,
  output logic             take_o,
  output logic             run_o,
  output logic             edge_inc_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             ss_act_o,
  output logic             land_o,
  output logic [W-1:0]     land_data_o
);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(2 * W - 1);

  xfer_st_e     st_q;
  logic [W-1:0] tx_sh_q;
  logic [W-1:0] rx_sh_q;
  logic         sck_q;
  logic         mosi_q;
  logic         ss_q;
  logic         last_trail;

  assign last_trail  = (st_q == ST_DATA) && tick_i && sck_q && (edge_cnt_i == LAST_EDGE);
  assign take_o      = tx_full_i && ((st_q == ST_IDLE) || ((st_q == ST_STOP) && tick_i));
  assign run_o       = (st_q != ST_IDLE);
  assign edge_inc_o  = (st_q == ST_START) || (st_q == ST_DATA);
  assign land_o      = last_trail;
  assign land_data_o = {miso_i, rx_sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (tx_full_i) begin
            tx_sh_q <= tx_word_i;
            ss_q    <= 1'b1;
            st_q    <= ST_START;
          end
        end
        ST_START: begin
          if (tick_i) begin
            sck_q   <= 1'b1;
            mosi_q  <= tx_sh_q[0];
            tx_sh_q <= {1'b0, tx_sh_q[W-1:1]};
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (sck_q) begin
              // trailing edge: sample
              sck_q   <= 1'b0;
              rx_sh_q <= {miso_i, rx_sh_q[W-1:1]};
              if (edge_cnt_i == LAST_EDGE) st_q <= ST_STOP;
            end else begin
              // leading edge: launch
              sck_q   <= 1'b1;
              mosi_q  <= tx_sh_q[0];
              tx_sh_q <= {1'b0, tx_sh_q[W-1:1]};
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (tx_full_i) begin
              tx_sh_q <= tx_word_i;
              st_q    <= ST_START;
            end else begin
              ss_q <= 1'b0;
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = mosi_q;
  assign ss_act_o = ss_q;
endmodule

// File: rtl/spi_tmr_master.sv
module spi_tmr_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_half_i,
  input  logic              cfg_sck_inv_i,
  input  logic              wr_en_i,
  input  logic              wr_rev_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_rev_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              ovr_err_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no,
  input  logic              miso_i
);
  logic              take;
  logic              run;
  logic              edge_inc;
  logic              tick;
  logic [CNT_W-1:0]  edge_cnt;
  logic              sck_raw;
  logic              ss_act;
  logic              land;
  logic [DATA_W-1:0] land_data;
  logic [DATA_W-1:0] tx_word;
  logic              tx_full;
  logic              rx_full;

  spi_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .reload_i   (take),
    .cmp_i      (cfg_half_i),
    .edge_clr_i (take),
    .edge_inc_i (edge_inc),
    .tick_o     (tick),
    .edge_cnt_o (edge_cnt)
  );

  spi_xfer_fsm #(.W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_full_i   (tx_full),
    .tx_word_i   (tx_word),
    .miso_i      (miso_i),
    .tick_i      (tick),
    .edge_cnt_i  (edge_cnt),
    .take_o      (take),
    .run_o       (run),
    .edge_inc_o  (edge_inc),
    .sck_o       (sck_raw),
    .mosi_o      (mosi_o),
    .ss_act_o    (ss_act),
    .land_o      (land),
    .land_data_o (land_data)
  );

  spi_data_bufs #(.W(DATA_W)) u_bufs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_rev_i    (wr_rev_i),
    .wr_data_i   (wr_data_i),
    .take_i      (take),
    .rd_en_i     (rd_en_i),
    .rd_rev_i    (rd_rev_i),
    .land_i      (land),
    .land_data_i (land_data),
    .rd_data_o   (rd_data_o),
    .tx_word_o   (tx_word),
    .tx_full_o   (tx_full),
    .rx_full_o   (rx_full),
    .ovr_o       (ovr_err_o)
  );

  assign sck_o    = sck_raw ^ cfg_sck_inv_i;
  assign ss_no    = ~ss_act;
  assign tx_req_o = ~tx_full;
  assign rx_req_o = rx_full;
endmodule

// File: rtl/spi_tmr_master_chk.sv
module spi_tmr_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_sck_inv_i,
  input logic wr_en_i,
  input logic rd_en_i,
  input logic sck_o,
  input logic mosi_o,
  input logic ss_no,
  input logic tx_req_o,
  input logic rx_req_o,
  input logic ovr_err_o,
  input logic land_i
);
  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> (sck_o == cfg_sck_inv_i));

  assert_sck_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cfg_sck_inv_i) && !$stable(sck_o)) |-> !ss_no);

  assert_mosi_on_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> (!$stable(sck_o) && (sck_o != cfg_sck_inv_i)));

  assert_tx_flag_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tx_req_o);

  assert_rx_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    land_i |=> rx_req_o);

  assert_rx_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !land_i) |=> !rx_req_o);

  assert_ovr_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (land_i && rx_req_o && !rd_en_i) |=> ovr_err_o);

  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o |=> ovr_err_o);
endmodule

bind spi_tmr_master spi_tmr_master_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_sck_inv_i (cfg_sck_inv_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .sck_o         (sck_o),
  .mosi_o        (mosi_o),
  .ss_no         (ss_no),
  .tx_req_o      (tx_req_o),
  .rx_req_o      (rx_req_o),
  .ovr_err_o     (ovr_err_o),
  .land_i        (land)
);

// File: tb/spi_tmr_master_tb.sv
module spi_tmr_master_tb;
  localparam int CLK_P = 10;
  localparam int W     = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   cfg_half = 8'd1;
  logic         sck_inv = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_rev = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic         rd_rev = 1'b0;
  logic [W-1:0] rd_data;
  logic         tx_req, rx_req, ovr_err, sck, mosi, ss_n;
  logic         miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint cyc = 0;

  spi_tmr_master #(.DATA_W(W), .CNT_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_half_i(cfg_half), .cfg_sck_inv_i(sck_inv),
    .wr_en_i(wr_en), .wr_rev_i(wr_rev), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_rev_i(rd_rev), .rd_data_o(rd_data),
    .tx_req_o(tx_req), .rx_req_o(rx_req), .ovr_err_o(ovr_err),
    .sck_o(sck), .mosi_o(mosi), .ss_no(ss_n), .miso_i(miso)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] brev(input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[W-1-i];
    return r;
  endfunction

  // slave model, clock phase 1
  bit           mon_en = 1'b0;
  int           hp_c = 1;
  logic [W-1:0] s_tx_q [4];
  logic [W-1:0] s_rx_hist [8];
  logic [W-1:0] s_rx_word = '0;
  int           s_ptr = 0;
  int           s_idx = 0;
  int           s_words = 0;
  int           ss_rise = 0;
  bit           first_in_sess = 1'b0;
  longint       ss_fall_t = 0;
  longint       last_t = 0;
  logic         lead;

  always @(negedge ss_n) if (mon_en) begin
    ss_fall_t = $time;
    first_in_sess = 1'b1;
  end

  always @(posedge ss_n) if (mon_en) ss_rise++;

  always @(sck) begin
    if (mon_en && ss_n === 1'b0) begin
      lead = (sck !== sck_inv);
      if (lead) begin
        if (s_idx == 0) begin
          if (first_in_sess)
            chk(($time - ss_fall_t) == longint'((hp_c+1)*CLK_P), "R2 start phase",
                $time - ss_fall_t, (hp_c+1)*CLK_P);
          else
            chk(($time - last_t) == longint'(2*(hp_c+1)*CLK_P), "R9 word gap",
                $time - last_t, 2*(hp_c+1)*CLK_P);
          first_in_sess = 1'b0;
        end else begin
          chk(($time - last_t) == longint'((hp_c+1)*CLK_P), "R2 half period",
              $time - last_t, (hp_c+1)*CLK_P);
        end
        miso = s_tx_q[s_ptr][s_idx];
      end else begin
        chk(($time - last_t) == longint'((hp_c+1)*CLK_P), "R2 half period",
            $time - last_t, (hp_c+1)*CLK_P);
        s_rx_word[s_idx] = mosi;
        s_idx++;
        if (s_idx == W) begin
          s_rx_hist[s_words % 8] = s_rx_word;
          s_words++;
          s_idx = 0;
          s_ptr = (s_ptr + 1) % 4;
        end
      end
      last_t = $time;
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    rst_ni = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    s_ptr = 0; s_idx = 0; s_words = 0; ss_rise = 0;
    mon_en = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1,    "R1 ss_no after reset", ss_n, 1);
    chk(sck == sck_inv,  "R1 sck idle after reset", sck, sck_inv);
    chk(tx_req == 1'b1,  "R1 tx_req after reset", tx_req, 1);
    chk(rx_req == 1'b0,  "R1 rx_req after reset", rx_req, 0);
    chk(ovr_err == 1'b0, "R1 ovr_err after reset", ovr_err, 0);
  endtask

  task automatic write_tx(input logic [W-1:0] d, input bit rev);
    wr_en = 1'b1; wr_data = d; wr_rev = rev;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_rx(input bit rev, output logic [W-1:0] d);
    rd_rev = rev;
    rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 20000 && s_words < n; i++) @(negedge clk);
    for (int i = 0; i < 2000 && ss_n !== 1'b1; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // single LSB-first word, no inversion
  task automatic t_basic();
    logic [W-1:0] d;
    hp_c = 1; cfg_half = 8'd1; sck_inv = 1'b0;
    s_tx_q[0] = 8'h3C; s_ptr = 0;
    @(negedge clk);
    write_tx(8'hA5, 1'b0);
    chk(tx_req == 1'b0, "R6 tx_req low after write", tx_req, 0);
    @(negedge clk);
    chk(tx_req == 1'b1, "R6 tx_req back after take", tx_req, 1);
    chk(ss_n == 1'b0, "R2 ss_no asserted in frame", ss_n, 0);
    wait_words(1);
    chk(s_rx_hist[0] == 8'hA5, "R4 wire bits lsb first", s_rx_hist[0], 8'hA5);
    chk(rx_req == 1'b1, "R7 rx_req after word", rx_req, 1);
    chk(ss_n == 1'b1, "R10 ss_no released", ss_n, 1);
    repeat (6) @(negedge clk);
    chk(sck == 1'b0, "R10 sck idle between words", sck, 0);
    read_rx(1'b0, d);
    chk(d == 8'h3C, "R5 straight read view", d, 8'h3C);
    chk(rx_req == 1'b0, "R7 rx_req cleared by read", rx_req, 0);
    chk(ss_rise == 1, "R10 one select window", ss_rise, 1);
  endtask

  // reversed views, inverted clock, longer half period
  task automatic t_rev();
    logic [W-1:0] d;
    hp_c = 3; cfg_half = 8'd3; sck_inv = 1'b1;
    s_tx_q[s_ptr] = 8'hC1;
    repeat (2) @(negedge clk);
    chk(sck == 1'b1, "R3 inverted idle level", sck, 1);
    write_tx(8'h1E, 1'b1);
    wait_words(2);
    chk(s_rx_hist[1] == brev(8'h1E), "R5 reversed write view", s_rx_hist[1], brev(8'h1E));
    chk(sck == 1'b1, "R3 inverted idle after frame", sck, 1);
    read_rx(1'b1, d);
    chk(d == brev(8'hC1), "R5 reversed read view", d, brev(8'hC1));
    sck_inv = 1'b0;
  endtask

  // back-to-back stream with a read landing on the completion cycle
  task automatic t_b2b();
    logic [W-1:0] d;
    longint n1;
    longint per;
    int rise0;
    int w0;
    int p0;
    hp_c = 2; cfg_half = 8'd2;
    per = longint'((hp_c+1)*(2*W+1));
    rise0 = ss_rise; w0 = s_words; p0 = s_ptr;
    s_tx_q[p0] = 8'h5A; s_tx_q[(p0+1)%4] = 8'h96;
    @(negedge clk);
    write_tx(8'h81, 1'b0);
    @(negedge clk);
    write_tx(8'h7E, 1'b0);
    chk(tx_req == 1'b0, "R6 tx_req low while word waits", tx_req, 0);
    for (int i = 0; i < 5000 && rx_req !== 1'b1; i++) @(negedge clk);
    n1 = cyc;
    while (cyc < n1 + per - 1) @(negedge clk);
    read_rx(1'b0, d);
    chk(d == 8'h5A, "R7 same-cycle read returns older word", d, 8'h5A);
    chk(rx_req == 1'b1, "R7 rx_req kept on same-cycle landing", rx_req, 1);
    chk(ovr_err == 1'b0, "R7 no overrun on same-cycle read", ovr_err, 0);
    chk(ss_n == 1'b0, "R9 select held across words", ss_n, 0);
    chk(s_words == w0 + 2, "R9 second word at expected period", s_words, w0 + 2);
    read_rx(1'b0, d);
    chk(d == 8'h96, "R9 second word received", d, 8'h96);
    wait_words(w0 + 2);
    chk(s_rx_hist[w0 % 8] == 8'h81, "R9 first word on wire", s_rx_hist[w0 % 8], 8'h81);
    chk(s_rx_hist[(w0+1) % 8] == 8'h7E, "R9 second word on wire", s_rx_hist[(w0+1) % 8], 8'h7E);
    chk(ss_rise == rise0 + 1, "R9 single window for stream", ss_rise, rise0 + 1);
  endtask

  // overrun at the fastest clock
  task automatic t_ovr();
    logic [W-1:0] d;
    int w0;
    hp_c = 0; cfg_half = 8'd0;
    w0 = s_words;
    s_tx_q[s_ptr] = 8'h11; s_tx_q[(s_ptr+1)%4] = 8'hE4;
    write_tx(8'h33, 1'b0);
    wait_words(w0 + 1);
    chk(ovr_err == 1'b0, "R8 no overrun on first word", ovr_err, 0);
    write_tx(8'hCC, 1'b0);
    wait_words(w0 + 2);
    chk(ovr_err == 1'b1, "R8 overrun set", ovr_err, 1);
    read_rx(1'b0, d);
    chk(d == 8'hE4, "R8 newer word replaces held word", d, 8'hE4);
    repeat (5) @(negedge clk);
    chk(ovr_err == 1'b1, "R8 overrun sticky", ovr_err, 1);
    do_reset();
  endtask

  initial begin
    do_reset();
    t_basic();
    t_rev();
    t_b2b();
    t_ovr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule